// File: doc/BRIEF.md
# Expanding-Opcode Instruction Decoder

This block is a purely combinational decoder for a 16-bit word-oriented instruction set. It takes the first word of an instruction and splits it into four 4-bit register and opcode fields. It sorts the word into one of three format classes: three-register, register-indexed or indexed-only. It also produces the control signals the datapath needs: an ALU operation select, a register-file write enable, memory read and write strobes, a jump kind, a flag saying that a displacement word follows, and a flag for encodings that name no instruction.

The 4-bit major opcode is expanded. Major values 0 to 13 are one-word arithmetic, compare, logic, shift and trap operations. For major values 14 and 15 the lowest field stops naming a source register and selects a sub-operation instead, and the instruction gains a second word. That second word is not decoded here. A sequencer uses the flag to fetch it, and the effective-address adder and register reads sit outside this block.

Top module: `xop_decoder`

## Requirements
- R1: The outputs `op_o`, `rd_o`, `ra_o` and `rb_o` equal word bits [15:12], [11:8], [7:4] and [3:0] for every input word.
- R2: `fmt_o` is 0 for major opcodes 0..13, 1 for major opcode 15 (register-indexed class), and 2 for major opcode 14 (indexed-only class).
- R3: `aux_word_o` is high exactly when the major opcode is 14 or 15, whether or not the sub-operation is legal.
- R4: `alu_sel_o` equals the major opcode for opcodes 0..12 (0 add, 1 subtract, 2 multiply, 3 divide, 4 less-than, 5 equal, 6 greater-than, 7 invert, 8 and, 9 or, 10 xor, 11 shift left, 12 shift right), and is 0 for every other opcode.
- R5: `rb_used_o` is high for opcodes 0..6 and 8..12. It is low for invert (7), trap (13), 14 and 15. For invert, the b field changes no output except `rb_o`.
- R6: `rf_we_o` is high for opcodes 0..12 and for opcode 15 with sub-operation 0 (load address), 1 (load) or 5 (jump and link), but only when the d field is non-zero. It is low in every other case.
- R7: `mem_rd_o` is high only for opcode 15 with sub-operation 1. `mem_wr_o` is high only for opcode 15 with sub-operation 2 (store). The two are never high together.
- R8: `jump_o` is 0 (none) except in these cases: 1 for opcode 14 with sub-operation 3, 2 for opcode 15 with sub-operation 3 (jump if false), 3 for opcode 15 with sub-operation 4 (jump if true), and 4 for opcode 15 with sub-operation 5 (jump and link).
- R9: `illegal_o` is high for opcode 15 with a sub-operation above 5, and for opcode 14 with a sub-operation other than 3. While it is high, `rf_we_o`, `mem_rd_o`, `mem_wr_o` and `jump_o` are all 0.
- R10: The trap opcode (13) gives no write, no memory access, no jump and no illegal flag, whatever its d, a and b fields hold.
- R11: For opcode 14 the d field has no effect on any output other than `rd_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opword_i | input | 16 | Operation word of the instruction |
| op_o | output | 4 | Major opcode field |
| rd_o | output | 4 | Destination register field |
| ra_o | output | 4 | First source or index register field |
| rb_o | output | 4 | Second source field or sub-operation |
| fmt_o | output | 2 | Format class: 0 three-register, 1 register-indexed, 2 indexed-only |
| alu_sel_o | output | 4 | ALU operation select |
| rb_used_o | output | 1 | Second source register is read |
| rf_we_o | output | 1 | Register-file write enable |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| jump_o | output | 3 | Jump kind: 0 none, 1 always, 2 if false, 3 if true, 4 link |
| aux_word_o | output | 1 | A displacement word follows |
| illegal_o | output | 1 | Encoding names no instruction |

## Verification
Every output is a combinational function of the word, so each result is due in the same cycle the word is applied, with no register in the path. The bench changes the word just after a rising edge and compares all outputs at the following falling edge, half a period later, against a behavioural model. A directed set of named encodings comes first. After that, all 65,536 words are swept, which covers the ignored-field and illegal-encoding cases completely.

// File: rtl/xop_pkg.sv
package xop_pkg;
  localparam int FIELD_W    = 4;
  localparam int NUM_FIELDS = 4;

  // field slots inside the packed field vector
  localparam int SLOT_OP = 3;
  localparam int SLOT_D  = 2;
  localparam int SLOT_A  = 1;
  localparam int SLOT_B  = 0;

  // major opcodes that matter to decode structure
  localparam int OP_INV     = 7;
  localparam int OP_LAST_ALU = 12;
  localparam int OP_TRAP    = 13;
  localparam int OP_XCLASS  = 14;
  localparam int OP_RXCLASS = 15;

  // register-indexed sub-operations
  localparam int RX_LEA   = 0;
  localparam int RX_LOAD  = 1;
  localparam int RX_STORE = 2;
  localparam int RX_JMPF  = 3;
  localparam int RX_JMPT  = 4;
  localparam int RX_JAL   = 5;
  // indexed-only sub-operation
  localparam int X_JUMP   = 3;

  typedef enum logic [1:0] {
    FMT_RRR = 2'd0,
    FMT_RX  = 2'd1,
    FMT_X   = 2'd2
  } fmt_e;

  typedef enum logic [2:0] {
    JMP_NONE     = 3'd0,
    JMP_ALWAYS   = 3'd1,
    JMP_IF_FALSE = 3'd2,
    JMP_IF_TRUE  = 3'd3,
    JMP_LINK     = 3'd4
  } jump_e;

  function automatic logic op_is_alu(input int op);
    return (op >= 0) && (op <= OP_LAST_ALU);
  endfunction

  function automatic logic op_reads_b(input int op);
    return op_is_alu(op) && (op != OP_INV);
  endfunction

  function automatic logic rx_sub_legal(input int sub);
    return (sub >= RX_LEA) && (sub <= RX_JAL);
  endfunction
endpackage

// File: rtl/xop_fields.sv
module xop_fields #(
  parameter int FIELD_W    = 4,
  parameter int NUM_FIELDS = 4,
  localparam int WORD_W    = FIELD_W * NUM_FIELDS
) (
  input  logic [WORD_W-1:0]                  word_i,
  output logic [NUM_FIELDS-1:0][FIELD_W-1:0] fld_o
);
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_slice
    assign fld_o[g] = word_i[g*FIELD_W +: FIELD_W];
  end
endmodule

// File: rtl/xop_rrr_dec.sv
module xop_rrr_dec
  import xop_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic [FIELD_W-1:0] op_i,
  output logic               rrr_hit_o,
  output logic               alu_wr_o,
  output logic               trap_o,
  output logic               rb_used_o,
  output logic [FIELD_W-1:0] alu_sel_o
);
  logic alu_hit;

  always_comb begin
    alu_hit   = op_is_alu(int'(op_i));
    rrr_hit_o = int'(op_i) <= OP_TRAP;
    trap_o    = int'(op_i) == OP_TRAP;
    alu_wr_o  = alu_hit;
    rb_used_o = op_reads_b(int'(op_i));
    alu_sel_o = alu_hit ? op_i : '0;

    // R5
    rb_in_class_chk: assert (!rb_used_o || (rrr_hit_o && !trap_o));
    // R4
    alu_sel_trap_chk: assert (!trap_o || (alu_sel_o == '0));
  end
endmodule

// File: rtl/xop_ext_dec.sv
module xop_ext_dec
  import xop_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic [FIELD_W-1:0] op_i,
  input  logic [FIELD_W-1:0] sub_i,
  output logic               rx_hit_o,
  output logic               x_hit_o,
  output logic               bad_o,
  output logic               ext_wr_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic [2:0]         jump_o
);
  logic rx_ok, x_ok;

  always_comb begin
    rx_hit_o = int'(op_i) == OP_RXCLASS;
    x_hit_o  = int'(op_i) == OP_XCLASS;
    rx_ok    = rx_hit_o && rx_sub_legal(int'(sub_i));
    x_ok     = x_hit_o && (int'(sub_i) == X_JUMP);
    bad_o    = (rx_hit_o && !rx_ok) || (x_hit_o && !x_ok);

    ext_wr_o = 1'b0;
    mem_rd_o = 1'b0;
    mem_wr_o = 1'b0;
    jump_o   = JMP_NONE;
    if (x_ok) begin
      jump_o = JMP_ALWAYS;
    end else if (rx_ok) begin
      case (int'(sub_i))
        RX_LEA:   ext_wr_o = 1'b1;
        RX_LOAD:  begin ext_wr_o = 1'b1; mem_rd_o = 1'b1; end
        RX_STORE: mem_wr_o = 1'b1;
        RX_JMPF:  jump_o = JMP_IF_FALSE;
        RX_JMPT:  jump_o = JMP_IF_TRUE;
        RX_JAL:   begin ext_wr_o = 1'b1; jump_o = JMP_LINK; end
        default:  ;
      endcase
    end

    // R7
    mem_excl_chk: assert (!(mem_rd_o && mem_wr_o));
    // R9
    bad_quiet_chk: assert (!bad_o || (!ext_wr_o && !mem_rd_o && !mem_wr_o && jump_o == JMP_NONE));
  end
endmodule

// File: rtl/xop_decoder.sv
module xop_decoder
  import xop_pkg::*;
#(
  parameter int FLD_W    = 4,
  localparam int NFLD    = 4,
  localparam int WORD_W  = FLD_W * NFLD
) (
  input  logic [WORD_W-1:0] opword_i,
  output logic [FLD_W-1:0]  op_o,
  output logic [FLD_W-1:0]  rd_o,
  output logic [FLD_W-1:0]  ra_o,
  output logic [FLD_W-1:0]  rb_o,
  output logic [1:0]        fmt_o,
  output logic [FLD_W-1:0]  alu_sel_o,
  output logic              rb_used_o,
  output logic              rf_we_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [2:0]        jump_o,
  output logic              aux_word_o,
  output logic              illegal_o
);
  logic [NFLD-1:0][FLD_W-1:0] fld;
  logic rrr_hit, alu_wr, trap_hit;
  logic rx_hit, x_hit, ext_bad, ext_wr;

  xop_fields #(.FIELD_W(FLD_W), .NUM_FIELDS(NFLD)) u_fields (
    .word_i (opword_i),
    .fld_o  (fld)
  );

  assign op_o = fld[SLOT_OP];
  assign rd_o = fld[SLOT_D];
  assign ra_o = fld[SLOT_A];
  assign rb_o = fld[SLOT_B];

  xop_rrr_dec #(.FIELD_W(FLD_W)) u_rrr (
    .op_i      (op_o),
    .rrr_hit_o (rrr_hit),
    .alu_wr_o  (alu_wr),
    .trap_o    (trap_hit),
    .rb_used_o (rb_used_o),
    .alu_sel_o (alu_sel_o)
  );

  xop_ext_dec #(.FIELD_W(FLD_W)) u_ext (
    .op_i     (op_o),
    .sub_i    (rb_o),
    .rx_hit_o (rx_hit),
    .x_hit_o  (x_hit),
    .bad_o    (ext_bad),
    .ext_wr_o (ext_wr),
    .mem_rd_o (mem_rd_o),
    .mem_wr_o (mem_wr_o),
    .jump_o   (jump_o)
  );

  always_comb begin
    if (rrr_hit)     fmt_o = FMT_RRR;
    else if (rx_hit) fmt_o = FMT_RX;
    else             fmt_o = FMT_X;
    aux_word_o = rx_hit || x_hit;
    illegal_o  = ext_bad;
    rf_we_o    = (alu_wr || ext_wr) && (rd_o != '0) && !ext_bad;

    // R6
    we_rd0_chk: assert (!(rf_we_o && rd_o == '0));
    // R3
    aux_fmt_chk: assert (aux_word_o == (fmt_o != FMT_RRR));
    // R8
    jump_aux_chk: assert ((jump_o == JMP_NONE) || aux_word_o);
    // R9
    illegal_quiet_chk: assert (!illegal_o || (!rf_we_o && !mem_rd_o && !mem_wr_o && jump_o == JMP_NONE));
    // R10
    trap_quiet_chk: assert (!trap_hit || (!rf_we_o && !mem_rd_o && !mem_wr_o && !illegal_o && jump_o == JMP_NONE));
  end
endmodule

// File: tb/test_xop_decoder.sv
module test_xop_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] opword;
  logic [3:0]  op_o, rd_o, ra_o, rb_o, alu_sel_o;
  logic [1:0]  fmt_o;
  logic        rb_used_o, rf_we_o, mem_rd_o, mem_wr_o, aux_word_o, illegal_o;
  logic [2:0]  jump_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  xop_decoder i_xop_decoder (
    .opword_i   (opword),
    .op_o       (op_o),
    .rd_o       (rd_o),
    .ra_o       (ra_o),
    .rb_o       (rb_o),
    .fmt_o      (fmt_o),
    .alu_sel_o  (alu_sel_o),
    .rb_used_o  (rb_used_o),
    .rf_we_o    (rf_we_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .jump_o     (jump_o),
    .aux_word_o (aux_word_o),
    .illegal_o  (illegal_o)
  );

  task automatic cmp(input string tag, input logic [15:0] w, input int act, input int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s word=%h actual=%0d expected=%0d", tag, w, act, exp);
    end
  endtask

  // behavioural model, applied to one word
  task automatic apply(input logic [15:0] w);
    int op, dst, src_a, sub;
    int e_fmt, e_alu, e_jmp;
    bit e_aux, e_rb, e_ill, e_rd, e_wr, writes;
    @(posedge clk);
    opword = w;
    op = int'(w[15:12]); dst = int'(w[11:8]); src_a = int'(w[7:4]); sub = int'(w[3:0]);
    e_fmt = (op == 15) ? 1 : (op == 14) ? 2 : 0;
    e_aux = op >= 14;
    e_alu = (op < 13) ? op : 0;
    e_rb  = (op < 13) && (op != 7);
    writes = 0; e_ill = 0; e_rd = 0; e_wr = 0; e_jmp = 0;
    if (op < 13) writes = 1;
    else if (op == 15) begin
      case (sub)
        0: writes = 1;
        1: begin writes = 1; e_rd = 1; end
        2: e_wr = 1;
        3: e_jmp = 2;
        4: e_jmp = 3;
        5: begin writes = 1; e_jmp = 4; end
        default: e_ill = 1;
      endcase
    end else if (op == 14) begin
      if (sub == 3) e_jmp = 1; else e_ill = 1;
    end
    @(negedge clk);
    vectors++;
    cmp("R1 op",  w, int'(op_o), op);
    cmp("R1 d",   w, int'(rd_o), dst);
    cmp("R1 a",   w, int'(ra_o), src_a);
    cmp("R1 b",   w, int'(rb_o), sub);
    cmp("R2 fmt", w, int'(fmt_o), e_fmt);
    cmp("R3 aux", w, int'(aux_word_o), int'(e_aux));
    cmp("R4 alu", w, int'(alu_sel_o), e_alu);
    cmp("R5 rb_used", w, int'(rb_used_o), int'(e_rb));
    cmp("R6 we",  w, int'(rf_we_o), int'(writes && dst != 0 && !e_ill));
    cmp("R7 mrd", w, int'(mem_rd_o), int'(e_rd));
    cmp("R7 mwr", w, int'(mem_wr_o), int'(e_wr));
    cmp("R8 jump", w, int'(jump_o), e_jmp);
    cmp("R9 illegal", w, int'(illegal_o), int'(e_ill));
  endtask

  initial begin
    opword = 16'h0000;
    apply(16'h0000);   // R6: add into register 0 writes nothing
    apply(16'h0415);   // R4: add
    apply(16'h2523);   // R4: multiply
    apply(16'h7310);   // R5: invert
    apply(16'h731F);   // R5: invert, b ignored
    apply(16'hC9AB);   // R4: last ALU op
    apply(16'hD000);   // R10: trap
    apply(16'hD5A7);   // R10: trap with non-zero fields
    apply(16'hF320);   // R6: load address
    apply(16'hF101);   // R7: load
    apply(16'hF102);   // R7: store
    apply(16'hF043);   // R8: jump if false
    apply(16'hF044);   // R8: jump if true
    apply(16'hF005);   // R6/R8: link to register 0
    apply(16'hF705);   // R8: link
    apply(16'hF106);   // R9: illegal sub-operation
    apply(16'hFF0F);   // R9: illegal sub-operation
    apply(16'hE003);   // R8: unconditional jump
    apply(16'hE503);   // R11: d field ignored
    apply(16'hE004);   // R9: illegal indexed-only
    for (int k = 0; k < 65536; k++) apply(16'(k));   // R1..R11 exhaustive
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired after %0d cycles", WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule